// File: doc/BRIEF.md
# Configuration Word Stream Checksum Monitor

This block sits beside a configuration port and watches a stream of 16-bit words, one per clock while `wordValid` is high. It parses packet headers, follows the payload of every type-1 write packet, and keeps a 22-bit running checksum. Each counted payload word is merged into the checksum together with the 6-bit address of the register that the packet targets.

Three cases change how payload words are treated. A write to the command register whose first payload word is the clear code empties the checksum. A write to the checksum register carries a 32-bit expected value. That value is compared against the checksum, and the checksum is then cleared. When automatic checking is enabled, the two words that follow a frame-data write packet are also an expected value. They are compared, but the checksum is kept. After every compare the block raises `compareDone` for one cycle. A mismatch flag stays set until reset.

The register addresses, the clear code and the automatic-check enable are parameters. The defaults are: checksum register 0x00, frame-data register 0x02, command register 0x05, clear code 0x0007, automatic check on.

Top module: `cfg_crc_monitor`

## Requirements
- R1: Reset (active-low `rstN`, asynchronous) sets `crcValue` to zero and clears `compareDone` and `mismatch`.
- R2: Each counted payload word updates the checksum one clock after it is accepted. The input vector is `v = {addr[5:0], data[15:0]}`. For every bit except 0, `next[i] = crc[i-1] ^ v[i]`. Bits 7, 12 and 15 also XOR in `crc[21]`. Bit 0 is `v[0] ^ crc[21]`.
- R3: A header word has the layout [15:13] type (001 = type 1), [12:11] op (10 = write, 01 = read, 00 = no-op), [10:5] register address and [4:0] word count. Header words never change the checksum, and neither do idle cycles. A read, a no-op, a zero-count write, or any header whose type is not 001 counts no payload.
- R4: Once a write packet's word count has been consumed, the next word is parsed as a header.
- R5: In a write to the command register, a first payload word equal to the clear code clears the checksum and is not merged. Any other command payload word is merged as in R2, including the clear code when it appears in a later position.
- R6: In a write to the checksum register, payload word 0 is the expected value's upper half and word 1 is its lower half. Neither word is merged. One clock after word 1, `compareDone` is high for exactly one cycle and `crcValue` is zero.
- R7: A compare flags a mismatch when bits 31..22 of the expected value are not all zero, or when bits 21..0 differ from the checksum held before the compare. `mismatch` then stays high until reset.
- R8: With automatic checking enabled, the two words after a frame-data write packet are an expected value, upper half first. They are compared as in R7 and are not merged. After this compare, `compareDone` pulses and the checksum keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wordValid | input | 1 | A stream word is present this cycle |
| wordData | input | 16 | Stream word |
| crcValue | output | 22 | Current running checksum |
| compareDone | output | 1 | One-cycle pulse after each compare |
| mismatch | output | 1 | Sticky compare-failure flag |

## Verification
Long single-packet runs of varied data check the update taps, because every word's result feeds the next word. A sweep of one-word writes to every ordinary address checks that the address field enters the vector at the right bits. Read, no-op, zero-count and type-2 headers are sent, and a header-like word is placed just after a packet ends. These patterns separate a parser that counts payload correctly from one that folds too much or too little. Compares are tried with exact, low-bit-wrong and upper-bit-wrong expected values, and in both the checksum-register form and the automatic form. This separates the clearing compare from the non-clearing one.

// File: rtl/cfg_crc_pkg.sv
`timescale 1ns/1ps
package cfg_crc_pkg;

  // Header type and opcode codes (type-1 packets only are followed)
  localparam logic [2:0] PKT_TYPE_ONE = 3'b001;
  localparam logic [1:0] PKT_OP_WRITE = 2'b10;

  // Parser states
  typedef enum logic [1:0] {
    PS_HEADER  = 2'd0,
    PS_PAYLOAD = 2'd1,
    PS_AUTO_HI = 2'd2,
    PS_AUTO_LO = 2'd3
  } parseState_t;

  // Strobes from control to datapath, valid for the current word
  typedef struct packed {
    logic fold;        // merge {addr, data} into the checksum
    logic clear;       // clear checksum (command)
    logic holdHi;      // capture upper half of an expected value
    logic compare;     // current word is the lower half: compare now
    logic clearAfter;  // clear the checksum as part of this compare
  } crcStrobes_t;

endpackage

// File: rtl/cfg_crc_step.sv
`timescale 1ns/1ps
// One parallel checksum step: shift toward the high index, feedback at taps
module cfg_crc_step #(
  parameter int unsigned CRC_W    = 22,
  parameter logic [31:0] TAP_MASK = 32'h0000_9081
) (
  input  logic [CRC_W-1:0] state,
  input  logic [CRC_W-1:0] foldIn,
  output logic [CRC_W-1:0] nextState
);

  logic feedback;
  assign feedback = state[CRC_W-1];

  for (genvar i = 0; i < CRC_W; i++) begin : g_bit
    if (i == 0) begin : g_low
      if (TAP_MASK[i]) begin : g_tap
        assign nextState[i] = foldIn[i] ^ feedback;
      end else begin : g_plain
        assign nextState[i] = foldIn[i];
      end
    end else begin : g_upper
      if (TAP_MASK[i]) begin : g_tap
        assign nextState[i] = state[i-1] ^ foldIn[i] ^ feedback;
      end else begin : g_plain
        assign nextState[i] = state[i-1] ^ foldIn[i];
      end
    end
  end

endmodule

// File: rtl/cfg_crc_ctrl.sv
`timescale 1ns/1ps
// Packet parser: decides what each stream word does to the checksum
module cfg_crc_ctrl
  import cfg_crc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 5,
  parameter logic [ADDR_W-1:0] CRC_REG_ADDR   = 6'h00,
  parameter logic [ADDR_W-1:0] FRAME_REG_ADDR = 6'h02,
  parameter logic [ADDR_W-1:0] CMD_REG_ADDR   = 6'h05,
  parameter logic [DATA_W-1:0] CLEAR_CODE     = 16'h0007,
  parameter bit                AUTO_CHECK_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [DATA_W-1:0] wordData,
  output crcStrobes_t       strobes,
  output logic [ADDR_W-1:0] curAddr
);

  // Header field positions, derived from the widths
  localparam int unsigned CNT_LSB  = 0;
  localparam int unsigned ADDR_LSB = CNT_LSB + CNT_W;
  localparam int unsigned OP_LSB   = ADDR_LSB + ADDR_W;
  localparam int unsigned TYPE_LSB = OP_LSB + 2;

  parseState_t       state, stateNext;
  logic [CNT_W-1:0]  remaining, remainingNext;
  logic [CNT_W-1:0]  wordIdx, wordIdxNext;
  logic [ADDR_W-1:0] addrNext;

  logic [2:0]        hdrType;
  logic [1:0]        hdrOp;
  logic [ADDR_W-1:0] hdrAddr;
  logic [CNT_W-1:0]  hdrCnt;
  logic              hdrStartsPayload;

  assign hdrType = wordData[TYPE_LSB +: 3];
  assign hdrOp   = wordData[OP_LSB +: 2];
  assign hdrAddr = wordData[ADDR_LSB +: ADDR_W];
  assign hdrCnt  = wordData[CNT_LSB +: CNT_W];
  assign hdrStartsPayload = (hdrType == PKT_TYPE_ONE) && (hdrOp == PKT_OP_WRITE)
                            && (hdrCnt != '0);

  logic atCrcReg, atCmdReg, atFrameReg, lastWord;
  assign atCrcReg   = (curAddr == CRC_REG_ADDR);
  assign atCmdReg   = (curAddr == CMD_REG_ADDR);
  assign atFrameReg = (curAddr == FRAME_REG_ADDR);
  assign lastWord   = (remaining == CNT_W'(1));

  always_comb begin
    stateNext     = state;
    remainingNext = remaining;
    wordIdxNext   = wordIdx;
    addrNext      = curAddr;
    strobes       = '0;
    if (wordValid) begin
      unique case (state)
        PS_HEADER: begin
          if (hdrStartsPayload) begin
            stateNext     = PS_PAYLOAD;
            remainingNext = hdrCnt;
            wordIdxNext   = '0;
            addrNext      = hdrAddr;
          end
        end
        PS_PAYLOAD: begin
          if (atCrcReg) begin
            if (wordIdx == CNT_W'(0)) begin
              strobes.holdHi = 1'b1;
            end else if (wordIdx == CNT_W'(1)) begin
              strobes.compare    = 1'b1;
              strobes.clearAfter = 1'b1;
            end
          end else if (atCmdReg && (wordIdx == CNT_W'(0)) && (wordData == CLEAR_CODE)) begin
            strobes.clear = 1'b1;
          end else begin
            strobes.fold = 1'b1;
          end
          remainingNext = remaining - CNT_W'(1);
          wordIdxNext   = wordIdx + CNT_W'(1);
          if (lastWord) begin
            stateNext = (AUTO_CHECK_EN && atFrameReg) ? PS_AUTO_HI : PS_HEADER;
          end
        end
        PS_AUTO_HI: begin
          strobes.holdHi = 1'b1;
          stateNext      = PS_AUTO_LO;
        end
        PS_AUTO_LO: begin
          strobes.compare = 1'b1;
          stateNext       = PS_HEADER;
        end
        default: stateNext = PS_HEADER;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= PS_HEADER;
      remaining <= '0;
      wordIdx   <= '0;
      curAddr   <= '0;
    end else begin
      state     <= stateNext;
      remaining <= remainingNext;
      wordIdx   <= wordIdxNext;
      curAddr   <= addrNext;
    end
  end

endmodule

// File: rtl/cfg_crc_datapath.sv
`timescale 1ns/1ps
// Checksum register, expected-value capture and compare
module cfg_crc_datapath
  import cfg_crc_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 6,
  parameter logic [31:0] TAP_MASK = 32'h0000_9081
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStrobes_t       strobes,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [DATA_W-1:0] wordData,
  output logic [ADDR_W+DATA_W-1:0] crcValue,
  output logic              compareDone,
  output logic              mismatch
);

  localparam int unsigned CRC_W = ADDR_W + DATA_W;
  localparam int unsigned EXP_W = 2 * DATA_W;

  logic [CRC_W-1:0]  crcState, crcStepped;
  logic [DATA_W-1:0] expectHi;
  logic [EXP_W-1:0]  expectWord;
  logic              upperNonZero, valueDiffers, compareBad;

  cfg_crc_step #(
    .CRC_W    (CRC_W),
    .TAP_MASK (TAP_MASK)
  ) u_step (
    .state     (crcState),
    .foldIn    ({curAddr, wordData}),
    .nextState (crcStepped)
  );

  assign expectWord   = {expectHi, wordData};
  assign upperNonZero = |expectWord[EXP_W-1:CRC_W];
  assign valueDiffers = (expectWord[CRC_W-1:0] != crcState);
  assign compareBad   = upperNonZero || valueDiffers;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcState <= '0;
    end else if (strobes.clear || (strobes.compare && strobes.clearAfter)) begin
      crcState <= '0;
    end else if (strobes.fold) begin
      crcState <= crcStepped;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expectHi <= '0;
    end else if (strobes.holdHi) begin
      expectHi <= wordData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      compareDone <= 1'b0;
      mismatch    <= 1'b0;
    end else begin
      compareDone <= strobes.compare;
      if (strobes.compare && compareBad) begin
        mismatch <= 1'b1;
      end
    end
  end

  assign crcValue = crcState;

endmodule

// File: rtl/cfg_crc_monitor.sv
`timescale 1ns/1ps
// Top: configuration word stream checksum monitor
module cfg_crc_monitor
  import cfg_crc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 5,
  parameter logic [31:0] TAP_MASK = 32'h0000_9081,
  parameter logic [ADDR_W-1:0] CRC_REG_ADDR   = 6'h00,
  parameter logic [ADDR_W-1:0] FRAME_REG_ADDR = 6'h02,
  parameter logic [ADDR_W-1:0] CMD_REG_ADDR   = 6'h05,
  parameter logic [DATA_W-1:0] CLEAR_CODE     = 16'h0007,
  parameter bit                AUTO_CHECK_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [DATA_W-1:0] wordData,
  output logic [ADDR_W+DATA_W-1:0] crcValue,
  output logic              compareDone,
  output logic              mismatch
);

  localparam int unsigned CRC_W = ADDR_W + DATA_W;

  crcStrobes_t       strobes;
  logic [ADDR_W-1:0] curAddr;

  cfg_crc_ctrl #(
    .DATA_W         (DATA_W),
    .ADDR_W         (ADDR_W),
    .CNT_W          (CNT_W),
    .CRC_REG_ADDR   (CRC_REG_ADDR),
    .FRAME_REG_ADDR (FRAME_REG_ADDR),
    .CMD_REG_ADDR   (CMD_REG_ADDR),
    .CLEAR_CODE     (CLEAR_CODE),
    .AUTO_CHECK_EN  (AUTO_CHECK_EN)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wordValid (wordValid),
    .wordData  (wordData),
    .strobes   (strobes),
    .curAddr   (curAddr)
  );

  cfg_crc_datapath #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .TAP_MASK (TAP_MASK)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .curAddr     (curAddr),
    .wordData    (wordData),
    .crcValue    (crcValue),
    .compareDone (compareDone),
    .mismatch    (mismatch)
  );

endmodule

// File: rtl/cfg_crc_monitor_checks.sv
`timescale 1ns/1ps
module cfg_crc_monitor_checks #(
  parameter int unsigned CRC_W = 22
) (
  input logic             clk,
  input logic             rstN,
  input logic             wordValid,
  input logic [CRC_W-1:0] crcValue,
  input logic             compareDone,
  input logic             mismatch
);

  // R1: a reset cycle leaves everything cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (crcValue == '0) && !compareDone && !mismatch);

  // R3: a cycle without a word never moves the checksum
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |=> $stable(crcValue));

  // R6: the compare pulse lasts a single cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    compareDone |=> !compareDone);

  // R7: the mismatch flag never drops while out of reset
  assert_mismatch_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    mismatch |=> mismatch);

  // R7: the mismatch flag only rises together with a compare pulse
  assert_mismatch_on_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mismatch) |-> compareDone);

endmodule

bind cfg_crc_monitor cfg_crc_monitor_checks #(.CRC_W(CRC_W)) u_checks (
  .clk         (clk),
  .rstN        (rstN),
  .wordValid   (wordValid),
  .crcValue    (crcValue),
  .compareDone (compareDone),
  .mismatch    (mismatch)
);

// File: tb/cfg_crc_monitor_test.sv
`timescale 1ns/1ps
module cfg_crc_monitor_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [15:0] wordData = '0;
  logic [21:0] crcValue;
  logic        compareDone;
  logic        mismatch;

  int errors = 0;
  int checks = 0;
  logic [21:0] model = '0;
  logic [21:0] expVal;

  always #2.5 clk = ~clk;

  cfg_crc_monitor uut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .crcValue(crcValue), .compareDone(compareDone), .mismatch(mismatch)
  );

  // Reference step from R2
  function automatic logic [21:0] stepModel(input logic [21:0] s,
                                            input logic [5:0] a,
                                            input logic [15:0] d);
    logic [21:0] v, n;
    v = {a, d};
    for (int i = 0; i < 22; i++) begin
      n[i] = v[i] ^ ((i > 0) ? s[i-1] : 1'b0);
      if (i == 0 || i == 7 || i == 12 || i == 15) n[i] = n[i] ^ s[21];
    end
    return n;
  endfunction

  // Header per R3: type 001, op, addr, count
  function automatic logic [15:0] hdr(input logic [1:0] op, input logic [5:0] a,
                                      input logic [4:0] cnt);
    return {3'b001, op, a, cnt};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic putWord(input logic [15:0] w);
    @(negedge clk);
    wordValid = 1'b1;
    wordData  = w;
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    model = '0;
  endtask

  // Write packet of n words; each merged and checked against the model (R2)
  task automatic foldWrite(input logic [5:0] a, input int n, input logic [15:0] seed);
    putWord(hdr(2'b10, a, 5'(n)));
    for (int k = 0; k < n; k++) begin
      logic [15:0] d;
      d = seed ^ 16'(k * 16'h3B71) ^ 16'(k << 9);
      putWord(d);
      model = stepModel(model, a, d);
      check("R2", "fold word", 32'(crcValue), 32'(model));
    end
  endtask

  initial begin
    #900000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    doReset();
    check("R1", "crc after reset", 32'(crcValue), 32'h0);
    check("R1", "done after reset", 32'(compareDone), 32'h0);
    check("R1", "mismatch after reset", 32'(mismatch), 32'h0);

    // R2: main fold
    foldWrite(6'h10, 4, 16'hA5C3);

    // R3: words that must not move the checksum
    putWord(hdr(2'b01, 6'h10, 5'd3));
    check("R3", "read header", 32'(crcValue), 32'(model));
    putWord(hdr(2'b10, 6'h11, 5'd0));
    check("R3", "zero count write", 32'(crcValue), 32'(model));
    putWord(hdr(2'b00, 6'h12, 5'd4));
    check("R3", "noop header", 32'(crcValue), 32'(model));
    putWord({3'b010, 13'h1ABC});
    check("R3", "type2 header", 32'(crcValue), 32'(model));
    repeat (5) @(negedge clk);
    check("R3", "idle cycles", 32'(crcValue), 32'(model));

    // R4: parser returns to headers after the count
    putWord(hdr(2'b10, 6'h03, 5'd1));
    putWord(16'hBEEF);
    model = stepModel(model, 6'h03, 16'hBEEF);
    check("R4", "single word packet", 32'(crcValue), 32'(model));
    putWord(16'hFFFF);
    check("R4", "word after packet is header", 32'(crcValue), 32'(model));
    putWord(hdr(2'b01, 6'h03, 5'd1));
    check("R4", "read header after packet", 32'(crcValue), 32'(model));

    // R2: address sweep (skip checksum and frame-data registers)
    for (int a = 0; a < 64; a++) begin
      if (a != 0 && a != 2) foldWrite(6'(a), 1, {6'(a), 10'h2A5});
    end

    // R2: long packets
    for (int p = 0; p < 8; p++) foldWrite(6'(6'h20 + p), 31, 16'(p * 16'h1111 + 1));

    // R5: clear command
    putWord(hdr(2'b10, 6'h05, 5'd2));
    putWord(16'h0007);
    model = '0;
    check("R5", "clear code clears", 32'(crcValue), 32'h0);
    putWord(16'h1234);
    model = stepModel(model, 6'h05, 16'h1234);
    check("R5", "second cmd word folds", 32'(crcValue), 32'(model));
    putWord(hdr(2'b10, 6'h05, 5'd1));
    putWord(16'h0008);
    model = stepModel(model, 6'h05, 16'h0008);
    check("R5", "other command folds", 32'(crcValue), 32'(model));
    putWord(hdr(2'b10, 6'h05, 5'd2));
    putWord(16'h0001);
    model = stepModel(model, 6'h05, 16'h0001);
    putWord(16'h0007);
    model = stepModel(model, 6'h05, 16'h0007);
    check("R5", "late clear code folds", 32'(crcValue), 32'(model));

    // R6/R7: matching checksum-register compare
    foldWrite(6'h07, 3, 16'h5A17);
    expVal = model;
    putWord(hdr(2'b10, 6'h00, 5'd2));
    putWord({10'h0, expVal[21:16]});
    check("R6", "upper half not folded", 32'(crcValue), 32'(model));
    check("R6", "no done after upper half", 32'(compareDone), 32'h0);
    putWord(expVal[15:0]);
    model = '0;
    check("R6", "done pulse", 32'(compareDone), 32'h1);
    check("R7", "no mismatch on match", 32'(mismatch), 32'h0);
    check("R6", "crc cleared after compare", 32'(crcValue), 32'h0);
    @(negedge clk);
    check("R6", "done drops", 32'(compareDone), 32'h0);

    // R8: automatic compare after a frame-data write
    foldWrite(6'h02, 2, 16'hC0DE);
    expVal = model;
    putWord({10'h0, expVal[21:16]});
    check("R8", "auto upper half not folded", 32'(crcValue), 32'(model));
    putWord(expVal[15:0]);
    check("R8", "auto done pulse", 32'(compareDone), 32'h1);
    check("R8", "auto match", 32'(mismatch), 32'h0);
    check("R8", "auto keeps crc", 32'(crcValue), 32'(model));
    putWord(hdr(2'b10, 6'h09, 5'd1));
    putWord(16'h4321);
    model = stepModel(model, 6'h09, 16'h4321);
    check("R8", "fold continues after auto", 32'(crcValue), 32'(model));

    // R7: wrong low bits
    expVal = model;
    putWord(hdr(2'b10, 6'h00, 5'd2));
    putWord({10'h0, expVal[21:16]});
    putWord(expVal[15:0] ^ 16'h0001);
    model = '0;
    check("R7", "mismatch on wrong value", 32'(mismatch), 32'h1);
    check("R6", "done on mismatch", 32'(compareDone), 32'h1);
    check("R6", "crc cleared on mismatch", 32'(crcValue), 32'h0);
    foldWrite(6'h0B, 2, 16'h7777);
    check("R7", "mismatch sticky", 32'(mismatch), 32'h1);

    // R1: reset clears the flag; R7: nonzero upper bits
    doReset();
    check("R1", "mismatch cleared by reset", 32'(mismatch), 32'h0);
    foldWrite(6'h0A, 2, 16'h9ABC);
    expVal = model;
    putWord(hdr(2'b10, 6'h00, 5'd2));
    putWord({10'h200, expVal[21:16]});
    putWord(expVal[15:0]);
    check("R7", "mismatch on upper bits", 32'(mismatch), 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule